// File: doc/BRIEF.md
# Matrix Result Hex Printer

This block takes a finished grid of unsigned results and prints it as readable ASCII text, one byte at a time, over a valid/ready byte handshake. The next stage is a serial transmitter. The default grid is four by four, with 18-bit values. A one-cycle start strobe does two things: it captures the whole result vector into internal storage, and it begins the text. After that the input vector may change freely.

The text has a fixed header line, then one line per grid row. A row opens with a bracket and a space. It holds the row's values as fixed-width, zero-padded, uppercase hexadecimal fields, separated by a comma and a space. It closes with a space and a bracket. Every line ends with carriage return and line feed. When the last line feed has been accepted, the block pulses `done` for one cycle and returns to idle.

Top module: `mxhex_printer`

## Requirements
- R1: While reset (`rst_n` low, active low) is applied and after it is released, `tx_valid` and `done` are low until a start is received.
- R2: After a start accepted in idle, the first bytes sent are the header text "RESULT MATRIX:" (14 bytes), followed by 0x0D then 0x0A.
- R3: Each of the ROWS lines that follow has the form 0x5B 0x20, value, 0x2C 0x20, value, ... value, 0x20 0x5D, 0x0D 0x0A. Row r, column c prints element index r*COLS+c, taken from bits [(r*COLS+c)*VAL_W +: VAL_W] of `result_in`. Rows go top to bottom and columns left to right.
- R4: Each value is printed as exactly ceil(VAL_W/4) hex digits (five by default), most significant first, with leading zeros kept. Digit values 0 to 9 are sent as 0x30 to 0x39. For 18-bit values the leading digit is always 0 to 3.
- R5: Digit values 10 to 15 are sent as uppercase letters 0x41 to 0x46. No lowercase letter 0x61 to 0x66 is ever sent.
- R6: Once `tx_valid` is high, it stays high with `tx_data` unchanged until a rising clock edge where `tx_ready` is high. Only that edge moves the printer to the next byte.
- R7: `done` is high for exactly the one cycle after the edge that accepts the final line feed. `tx_valid` is low in that cycle and stays low until the next start.
- R8: A start received while a print is in progress is ignored. Changes to `result_in` after the accepted start have no effect on the text.
- R9: A new start accepted right after `done` prints a complete new text from the newly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to capture `result_in` and print |
| result_in | input | ROWS*COLS*VAL_W | Packed result grid, element r*COLS+c at slice r*COLS+c |
| tx_data | output | 8 | ASCII byte offered to the transmitter |
| tx_valid | output | 1 | `tx_data` holds a byte to send |
| tx_ready | input | 1 | Transmitter takes the byte at this edge |
| done | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
The value sweeps run every nibble value through every digit position and include all-zero and all-ones grids. A printer that drops leading zeros, prints lowercase letters or takes the wrong slice of the vector fails on exact byte comparisons. Back-pressure patterns (always ready, sparse ready, pseudo-random ready) expose a printer that advances or changes its byte while `tx_ready` is low: such a printer would skip or duplicate characters. One run pulses start in the middle of a print and inverts the input vector. A design that restarts, or that reads live inputs, would then send a second header or the wrong digits. The checks on `done` catch a pulse that comes early, lasts too long, or overlaps a valid byte.

// File: rtl/mxp_pkg.sv
package mxp_pkg;

   localparam logic [7:0] CH_LBRK  = 8'h5B;
   localparam logic [7:0] CH_RBRK  = 8'h5D;
   localparam logic [7:0] CH_SPACE = 8'h20;
   localparam logic [7:0] CH_COMMA = 8'h2C;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HEAD,
      PH_OPEN,
      PH_DIG,
      PH_SEP,
      PH_CLOSE,
      PH_CR,
      PH_LF
   } mxp_phase_e;

   // Nibble to uppercase ASCII hex character
   function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
      if (nib < 4'd10) nib_to_ascii = 8'h30 + {4'd0, nib};
      else             nib_to_ascii = 8'h37 + {4'd0, nib};
   endfunction

endpackage

// File: rtl/mxp_hex_digit.sv
module mxp_hex_digit #(
   parameter int VAL_W = 18,
   parameter int IDX_W = 4
) (
   input  logic [VAL_W-1:0] val,
   input  logic [IDX_W-1:0] dig_idx,  // 0 selects the most significant digit
   output logic [7:0]       ascii
);
   import mxp_pkg::*;

   localparam int DIGITS = (VAL_W + 3) / 4;
   localparam int PAD    = DIGITS * 4 - VAL_W;

   logic [DIGITS*4-1:0] padded;

   generate
      if (PAD > 0) begin : g_pad
         assign padded = {{PAD{1'b0}}, val};
      end else begin : g_nopad
         assign padded = val;
      end
   endgenerate

   logic [3:0] nib;

   always_comb begin
      nib = 4'd0;
      if (int'(dig_idx) < DIGITS)
         nib = padded[4*(DIGITS-1-int'(dig_idx)) +: 4];
   end

   assign ascii = nib_to_ascii(nib);

endmodule

// File: rtl/mxp_text_rom.sv
module mxp_text_rom #(
   parameter int                    HEAD_LEN  = 14,
   parameter logic [8*HEAD_LEN-1:0] HEAD_TEXT = "RESULT MATRIX:",
   parameter int                    IDX_W     = 4
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       ch
);
   always_comb begin
      ch = 8'h00;
      if (int'(idx) < HEAD_LEN)
         ch = HEAD_TEXT[8*(HEAD_LEN-1-int'(idx)) +: 8];
   end
endmodule

// File: rtl/mxp_value_store.sv
module mxp_value_store #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int VAL_W = 18,
   parameter int ROW_W = 2,
   parameter int COL_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [ROWS*COLS*VAL_W-1:0]  grid_in,
   input  logic [ROW_W-1:0]            row,
   input  logic [COL_W-1:0]            col,
   output logic [VAL_W-1:0]            val
);
   localparam int N = ROWS * COLS;

   logic [N*VAL_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (load) held <= grid_in;
   end

   always_comb begin
      val = '0;
      if (int'(row) < ROWS && int'(col) < COLS)
         val = held[(int'(row)*COLS + int'(col))*VAL_W +: VAL_W];
   end
endmodule

// File: rtl/mxhex_printer.sv
module mxhex_printer #(
   parameter int                    ROWS      = 4,
   parameter int                    COLS      = 4,
   parameter int                    VAL_W     = 18,
   parameter int                    HEAD_LEN  = 14,
   parameter logic [8*HEAD_LEN-1:0] HEAD_TEXT = "RESULT MATRIX:"
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ROWS*COLS*VAL_W-1:0] result_in,
   output logic [7:0]                 tx_data,
   output logic                       tx_valid,
   input  logic                       tx_ready,
   output logic                       done
);
   import mxp_pkg::*;

   localparam int DIGITS  = (VAL_W + 3) / 4;
   localparam int POS_MAX = (HEAD_LEN > DIGITS) ? ((HEAD_LEN > 2) ? HEAD_LEN : 2)
                                                : ((DIGITS > 2) ? DIGITS : 2);
   localparam int POS_W   = $clog2(POS_MAX + 1);
   localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1;

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_grid
         $error("mxhex_printer: ROWS and COLS must be at least 1");
      end
      if (VAL_W < 1) begin : g_bad_width
         $error("mxhex_printer: VAL_W must be at least 1");
      end
      if (HEAD_LEN < 1) begin : g_bad_head
         $error("mxhex_printer: HEAD_LEN must be at least 1");
      end
   endgenerate

   mxp_phase_e       phase;
   logic [POS_W-1:0] pos;
   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;
   logic             in_head;

   logic             fire;
   logic             load;
   logic [VAL_W-1:0] cur_val;
   logic [7:0]       dig_ch;
   logic [7:0]       head_ch;

   assign load = start && (phase == PH_IDLE);
   assign fire = tx_valid && tx_ready;

   mxp_value_store #(
      .ROWS(ROWS), .COLS(COLS), .VAL_W(VAL_W), .ROW_W(ROW_W), .COL_W(COL_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .grid_in (result_in),
      .row     (row),
      .col     (col),
      .val     (cur_val)
   );

   mxp_hex_digit #(.VAL_W(VAL_W), .IDX_W(POS_W)) u_digit (
      .val     (cur_val),
      .dig_idx (pos),
      .ascii   (dig_ch)
   );

   mxp_text_rom #(.HEAD_LEN(HEAD_LEN), .HEAD_TEXT(HEAD_TEXT), .IDX_W(POS_W)) u_rom (
      .idx (pos),
      .ch  (head_ch)
   );

   // Character selection from the current phase and position
   always_comb begin
      unique case (phase)
         PH_HEAD:  tx_data = head_ch;
         PH_OPEN:  tx_data = (pos == '0) ? CH_LBRK  : CH_SPACE;
         PH_DIG:   tx_data = dig_ch;
         PH_SEP:   tx_data = (pos == '0) ? CH_COMMA : CH_SPACE;
         PH_CLOSE: tx_data = (pos == '0) ? CH_SPACE : CH_RBRK;
         PH_CR:    tx_data = CH_CR;
         PH_LF:    tx_data = CH_LF;
         default:  tx_data = 8'h00;
      endcase
   end

   assign tx_valid = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         pos     <= '0;
         row     <= '0;
         col     <= '0;
         in_head <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               phase   <= PH_HEAD;
               pos     <= '0;
               row     <= '0;
               col     <= '0;
               in_head <= 1'b1;
            end
         end else if (fire) begin
            unique case (phase)
               PH_HEAD: begin
                  if (pos == POS_W'(HEAD_LEN - 1)) begin
                     phase <= PH_CR;
                     pos   <= '0;
                  end else begin
                     pos <= pos + 1'b1;
                  end
               end
               PH_OPEN: begin
                  if (pos == '0) begin
                     pos <= pos + 1'b1;
                  end else begin
                     phase <= PH_DIG;
                     pos   <= '0;
                     col   <= '0;
                  end
               end
               PH_DIG: begin
                  if (pos == POS_W'(DIGITS - 1)) begin
                     pos   <= '0;
                     phase <= (col == COL_W'(COLS - 1)) ? PH_CLOSE : PH_SEP;
                  end else begin
                     pos <= pos + 1'b1;
                  end
               end
               PH_SEP: begin
                  if (pos == '0) begin
                     pos <= pos + 1'b1;
                  end else begin
                     phase <= PH_DIG;
                     pos   <= '0;
                     col   <= col + 1'b1;
                  end
               end
               PH_CLOSE: begin
                  if (pos == '0) begin
                     pos <= pos + 1'b1;
                  end else begin
                     phase <= PH_CR;
                     pos   <= '0;
                  end
               end
               PH_CR: phase <= PH_LF;
               PH_LF: begin
                  pos <= '0;
                  if (in_head) begin
                     in_head <= 1'b0;
                     phase   <= PH_OPEN;
                  end else if (row == ROW_W'(ROWS - 1)) begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end else begin
                     row   <= row + 1'b1;
                     phase <= PH_OPEN;
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/mxhex_printer_chk.sv
module mxhex_printer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [7:0] tx_data,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       done
);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_lf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(tx_valid && tx_ready && (tx_data == 8'h0A)));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tx_valid);

   assert_no_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !((tx_data >= 8'h61) && (tx_data <= 8'h66)));

   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind mxhex_printer mxhex_printer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .tx_data  (tx_data),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .done     (done)
);

// File: tb/mxhex_printer_test.sv
`timescale 1ns/1ps
module mxhex_printer_test;
   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int VAL_W = 18;
   localparam int N     = ROWS * COLS;
   localparam int MAXB  = 256;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start = 1'b0;
   logic [N*VAL_W-1:0]     result_in = '0;
   logic [7:0]             tx_data;
   logic                   tx_valid;
   logic                   tx_ready = 1'b0;
   logic                   done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [VAL_W-1:0] vals [N];
   logic [7:0]       exp_b [MAXB];
   string            exp_t [MAXB];
   int               nexp;

   always #2.5 clk = ~clk;

   mxhex_printer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .result_in(result_in),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done)
   );

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int got, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, expv);
      end
   endtask

   function automatic logic [7:0] hexch(input int n);
      return (n < 10) ? 8'(8'h30 + n) : 8'(8'h41 + n - 10);
   endfunction

   task automatic push(input logic [7:0] b, input string t);
      exp_b[nexp] = b;
      exp_t[nexp] = t;
      nexp++;
   endtask

   // Expected text computed from the requirements
   task automatic build_expected();
      string hdr;
      hdr = "RESULT MATRIX:";
      nexp = 0;
      for (int i = 0; i < hdr.len(); i++) push(hdr[i], "R2");
      push(8'h0D, "R2"); push(8'h0A, "R2");
      for (int r = 0; r < ROWS; r++) begin
         push(8'h5B, "R3"); push(8'h20, "R3");
         for (int c = 0; c < COLS; c++) begin
            for (int d = 4; d >= 0; d--) begin
               int nib;
               nib = int'((vals[r*COLS+c] >> (4*d)) & 18'hF);
               push(hexch(nib), (nib >= 10) ? "R5" : "R4");
            end
            if (c != COLS - 1) begin push(8'h2C, "R3"); push(8'h20, "R3"); end
         end
         push(8'h20, "R3"); push(8'h5D, "R3");
         push(8'h0D, "R3"); push(8'h0A, "R3");
      end
   endtask

   task automatic run_print(input int mode, input bit disturb, input string tag);
      int  got;
      int  guard;
      bit  hold;
      bit  did;
      logic [7:0] hold_d;
      build_expected();
      for (int i = 0; i < N; i++) result_in[i*VAL_W +: VAL_W] = vals[i];
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      got = 0; guard = 0; hold = 0; did = 0; hold_d = 8'h00;
      while (got < nexp && guard < 5000) begin
         case (mode)
            0: tx_ready = 1'b1;
            1: tx_ready = lfsr[0];
            default: tx_ready = ((guard % 3) == 2);
         endcase
         if (start) start = 1'b0;
         if (disturb && !did && got == 20) begin
            start = 1'b1;
            result_in = ~result_in;
            did = 1;
         end
         if (hold)
            check(tx_valid && tx_data == hold_d, "R6", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, hold_d});
         check(!done, "R7", done, 0);
         if (tx_valid && tx_ready) begin
            check(tx_data == exp_b[got], exp_t[got], tx_data, exp_b[got]);
            if (disturb && did) check(1'b1, "R8", 0, 0);
            got++;
         end else if (!tx_valid) begin
            check(1'b0, tag, 0, 1);
         end
         hold   = tx_valid && !tx_ready;
         hold_d = tx_data;
         guard++;
         @(negedge clk);
      end
      start = 1'b0;
      check(got == nexp, tag, got, nexp);
      check(done == 1'b1, "R7", done, 1);
      check(tx_valid == 1'b0, "R7", tx_valid, 0);
      tx_ready = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R7", done, 0);
      check(tx_valid == 1'b0, "R7", tx_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0, "R1", tx_valid, 0);
      check(done == 1'b0, "R1", done, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(tx_valid == 1'b0, "R1", tx_valid, 0);
      check(done == 1'b0, "R1", done, 0);

      // All zeros: leading zeros kept (R4)
      for (int i = 0; i < N; i++) vals[i] = '0;
      run_print(0, 0, "R4");

      // All ones: top digit limited to 3, letters uppercase (R4, R5)
      for (int i = 0; i < N; i++) vals[i] = 18'h3FFFF;
      run_print(2, 0, "R5");

      // Nibble sweep: every nibble value in every digit position (R3, R4, R5)
      for (int i = 0; i < N; i++) vals[i] = 18'((20'h11111 * i) & 20'h3FFFF);
      run_print(1, 0, "R3");

      // Start and input changes mid-print are ignored (R8)
      for (int i = 0; i < N; i++) vals[i] = 18'((i * 18'h0B3C7 + 18'h1D2A5) & 18'h3FFFF);
      run_print(1, 1, "R8");

      // Back-to-back restart after done (R9), distinct per-element values (R3)
      for (int i = 0; i < N; i++) vals[i] = 18'((i << 12) | (18'h00F00 >> (i % 4)) | i);
      run_print(0, 0, "R9");
      for (int i = 0; i < N; i++) vals[i] = 18'(18'h2A5C3 ^ (i * 18'h01357));
      run_print(2, 0, "R9");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule